// File: doc/BRIEF.md
# Shift and Rotate Unit with Selectable Silicon Revision

This unit carries out the four single-bit shift and rotate operations of an 8-bit accumulator CPU core: arithmetic left shift, logical right shift, rotate left through carry and rotate right through carry. The core presents an operation code, the operand and its current status byte with a valid strobe. One clock later the unit returns the shifted value, the updated status byte and a one-cycle valid pulse.

A mode input selects how rotate-right behaves. With the mode low, rotate-right is correct. With the mode high, the unit copies a known defective early revision. In that revision the decoder drives three ALU controls wrongly for rotate-right: the shift direction, the fill-bit source and the carry write enable. Rotate-right then shifts left, fills bit 0 with zero and leaves carry unchanged. N and Z still follow the wrong result. The operation is decoded into those three controls in one module, and a separate datapath module applies them, so the fault is modelled exactly where it arises.

Top module: `shift_rot_unit`

## Requirements
- R1: A synchronous reset, held through a rising clock edge, clears the result, the status output and the valid output to zero.
- R2: Operation codes are 2'b00 arithmetic shift left, 2'b01 logical shift right, 2'b10 rotate left, 2'b11 rotate right. On the edge where the valid input is 1, the result and status outputs take their new values and the valid output is 1 for that cycle. After an edge with the valid input 0, the valid output is 0 and the result and status outputs hold their values.
- R3: Arithmetic shift left gives {operand[6:0],0}, and carry (status bit 0) becomes operand bit 7.
- R4: Logical shift right gives {0,operand[7:1]}, carry becomes operand bit 0, and N (status bit 7) is always 0.
- R5: Rotate left gives {operand[6:0],carry-in}, and carry becomes operand bit 7.
- R6: With the mode low, rotate right gives {carry-in,operand[7:1]}, and carry becomes operand bit 0.
- R7: With the mode high, rotate right gives {operand[6:0],0} whatever the carry input (0x01 gives 0x02, 0xFF gives 0xFE, 0x80 gives 0x00).
- R8: With the mode high, rotate right leaves the carry output equal to the carry input.
- R9: For every operation in both modes, N equals result bit 7 and Z (status bit 1) is 1 exactly when the result is zero.
- R10: Status bits 6 down to 2 pass from the status input to the status output unchanged for every operation in both modes.
- R11: The mode input has no effect on arithmetic shift left, logical shift right or rotate left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| earlyRev | input | 1 | 1 selects the defective rotate-right behaviour |
| inValid | input | 1 | Operation strobe |
| opSel | input | 2 | Operation code |
| operand | input | 8 | Value to shift or rotate |
| statusIn | input | 8 | Status byte before the operation |
| result | output | 8 | Shifted or rotated value |
| statusOut | output | 8 | Status byte after the operation |
| outValid | output | 1 | One-cycle pulse marking new outputs |

## Verification
The result, the status byte and the valid pulse are all due on the first rising edge after the strobe. The bench drives each stimulus on a falling edge, lets exactly one rising edge pass and samples on the next falling edge. It then drops the strobe and checks, one edge later, that the valid output has cleared and the outputs are unchanged. Every operation code, in both modes, is swept over all 256 operands with both carry values. The other status bits carry a pattern that varies with the operand.

// File: rtl/shift_rot_pkg.sv
package shift_rot_pkg;

  localparam int OP_W = 2;

  typedef enum logic [OP_W-1:0] {
    OP_ASL = 2'b00,
    OP_LSR = 2'b01,
    OP_ROL = 2'b10,
    OP_ROR = 2'b11
  } shiftOp_e;

  typedef enum logic {
    FILL_ZERO  = 1'b0,
    FILL_CARRY = 1'b1
  } fillSrc_e;

  // Strobes handed from the decoder to the datapath
  typedef struct packed {
    logic     load;       // capture a new operation this edge
    logic     shiftLeft;  // 1: toward MSB, 0: toward LSB
    fillSrc_e fillSrc;    // bit shifted in at the vacated end
    logic     carryWrite; // 1: carry takes the bit shifted out
  } aluCtrl_t;

endpackage

// File: rtl/shift_rot_ctrl.sv
module shift_rot_ctrl
  import shift_rot_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 earlyRev,
  input  logic                 inValid,
  input  logic [OP_W-1:0]      opSel,
  output aluCtrl_t             ctrl,
  output logic                 outValid
);

  shiftOp_e opCode;
  aluCtrl_t normCtrl;
  aluCtrl_t faultCtrl;
  logic     useFault;

  assign opCode = shiftOp_e'(opSel);

  // Correct decode of every operation
  always_comb begin
    normCtrl      = '0;
    normCtrl.load = inValid;
    unique case (opCode)
      OP_ASL: begin
        normCtrl.shiftLeft  = 1'b1;
        normCtrl.fillSrc    = FILL_ZERO;
        normCtrl.carryWrite = 1'b1;
      end
      OP_LSR: begin
        normCtrl.shiftLeft  = 1'b0;
        normCtrl.fillSrc    = FILL_ZERO;
        normCtrl.carryWrite = 1'b1;
      end
      OP_ROL: begin
        normCtrl.shiftLeft  = 1'b1;
        normCtrl.fillSrc    = FILL_CARRY;
        normCtrl.carryWrite = 1'b1;
      end
      OP_ROR: begin
        normCtrl.shiftLeft  = 1'b0;
        normCtrl.fillSrc    = FILL_CARRY;
        normCtrl.carryWrite = 1'b1;
      end
      default: normCtrl = '0;
    endcase
  end

  // Early revision: all three rotate-right controls come out wrong
  always_comb begin
    faultCtrl            = normCtrl;
    faultCtrl.shiftLeft  = 1'b1;
    faultCtrl.fillSrc    = FILL_ZERO;
    faultCtrl.carryWrite = 1'b0;
  end

  assign useFault = earlyRev && (opCode == OP_ROR);
  assign ctrl     = useFault ? faultCtrl : normCtrl;

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end

  // R4: the logical right shift never goes left or fills with carry
  a_r4_lsr_right: assert property (@(posedge clk) disable iff (rst)
    (opCode == OP_LSR) |-> (!ctrl.shiftLeft && ctrl.fillSrc == FILL_ZERO));

  // R11: the mode input alters no control except for rotate right
  a_r11_mode_scope: assert property (@(posedge clk) disable iff (rst)
    (opCode != OP_ROR) |-> ctrl.carryWrite);

  // R2: valid pulse follows the strobe by one edge
  a_r2_valid_follow: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);
  a_r2_valid_drop: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);

endmodule

// File: rtl/shift_rot_dp.sv
module shift_rot_dp
  import shift_rot_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int NEG_BIT   = 7,
  parameter int ZERO_BIT  = 1,
  parameter int CARRY_BIT = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  aluCtrl_t          ctrl,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] statusIn,
  output logic [DATA_W-1:0] result,
  output logic [DATA_W-1:0] statusOut
);

  localparam int MSB = DATA_W - 1;

  logic              carryIn;
  logic              fillBit;
  logic              outBit;
  logic [DATA_W-1:0] shifted;
  logic              newCarry;
  logic [DATA_W-1:0] nextStatus;

  assign carryIn = statusIn[CARRY_BIT];
  assign fillBit = (ctrl.fillSrc == FILL_CARRY) ? carryIn : 1'b0;

  always_comb begin
    if (ctrl.shiftLeft) begin
      shifted = {operand[MSB-1:0], fillBit};
      outBit  = operand[MSB];
    end else begin
      shifted = {fillBit, operand[MSB:1]};
      outBit  = operand[0];
    end
  end

  assign newCarry = ctrl.carryWrite ? outBit : carryIn;

  // Per-bit status assembly: flag bits are computed, the rest pass
  for (genvar b = 0; b < DATA_W; b++) begin : g_status
    if (b == NEG_BIT) begin : g_neg
      assign nextStatus[b] = shifted[MSB];
    end else if (b == ZERO_BIT) begin : g_zero
      assign nextStatus[b] = (shifted == '0);
    end else if (b == CARRY_BIT) begin : g_carry
      assign nextStatus[b] = newCarry;
    end else begin : g_pass
      assign nextStatus[b] = statusIn[b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      statusOut <= '0;
    end else if (ctrl.load) begin
      result    <= shifted;
      statusOut <= nextStatus;
    end
  end

  // R2: outputs hold while no operation is captured
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !ctrl.load |=> ($stable(result) && $stable(statusOut)));

  // R9: N and Z track the registered result
  a_r9_flags: assert property (@(posedge clk) disable iff (rst)
    ctrl.load |=> (statusOut[NEG_BIT] == result[MSB] &&
                   statusOut[ZERO_BIT] == (result == '0)));

  // R8: with carry write disabled the carry survives the operation
  a_r8_carry_keep: assert property (@(posedge clk) disable iff (rst)
    (ctrl.load && !ctrl.carryWrite) |=>
      statusOut[CARRY_BIT] == $past(statusIn[CARRY_BIT]));

  // R10: untouched status bits pass through (default layout)
  a_r10_pass: assert property (@(posedge clk) disable iff (rst)
    ctrl.load |=> statusOut[6:2] == $past(statusIn[6:2]));

endmodule

// File: rtl/shift_rot_unit.sv
module shift_rot_unit
  import shift_rot_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       earlyRev,
  input  logic       inValid,
  input  logic [1:0] opSel,
  input  logic [7:0] operand,
  input  logic [7:0] statusIn,
  output logic [7:0] result,
  output logic [7:0] statusOut,
  output logic       outValid
);

  aluCtrl_t ctrl;

  shift_rot_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .earlyRev (earlyRev),
    .inValid  (inValid),
    .opSel    (opSel),
    .ctrl     (ctrl),
    .outValid (outValid)
  );

  shift_rot_dp #(
    .DATA_W    (8),
    .NEG_BIT   (7),
    .ZERO_BIT  (1),
    .CARRY_BIT (0)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .ctrl      (ctrl),
    .operand   (operand),
    .statusIn  (statusIn),
    .result    (result),
    .statusOut (statusOut)
  );

endmodule

// File: tb/tb_shift_rot_unit.sv
`timescale 1ns/1ps
module tb_shift_rot_unit;

  logic       clk = 1'b0;
  logic       rst;
  logic       earlyRev;
  logic       inValid;
  logic [1:0] opSel;
  logic [7:0] operand;
  logic [7:0] statusIn;
  logic [7:0] result;
  logic [7:0] statusOut;
  logic       outValid;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  shift_rot_unit dut (
    .clk(clk), .rst(rst), .earlyRev(earlyRev), .inValid(inValid),
    .opSel(opSel), .operand(operand), .statusIn(statusIn),
    .result(result), .statusOut(statusOut), .outValid(outValid)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string opTag(input logic [1:0] op, input logic rev);
    case (op)
      2'b00: return rev ? "R3/R11 asl" : "R3 asl";
      2'b01: return rev ? "R4/R11 lsr" : "R4 lsr";
      2'b10: return rev ? "R5/R11 rol" : "R5 rol";
      default: return rev ? "R7/R8 ror-early" : "R6 ror";
    endcase
  endfunction

  task automatic runOne(input logic [1:0] op, input logic rev,
                        input logic [7:0] a, input logic [7:0] st);
    logic [7:0] r;
    logic       c;
    logic [7:0] s;
    case (op)
      2'b00: begin r = a << 1; c = a[7]; end
      2'b01: begin r = a >> 1; c = a[0]; end
      2'b10: begin r = {a[6:0], st[0]}; c = a[7]; end
      default: begin
        if (rev) begin r = {a[6:0], 1'b0}; c = st[0]; end
        else     begin r = {st[0], a[7:1]}; c = a[0]; end
      end
    endcase
    s = st;
    s[7] = r[7];
    s[1] = (r == 8'h00);
    s[0] = c;
    @(negedge clk);
    opSel = op; earlyRev = rev; operand = a; statusIn = st; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check({opTag(op, rev), " result"}, result, r);
    check({opTag(op, rev), " carry"}, statusOut[0], c);
    check("R9 N/Z", {statusOut[7], statusOut[1]}, {s[7], s[1]});
    check("R10 passthrough", statusOut[6:2], st[6:2]);
    check("R2 valid pulse", outValid, 1);
    // Inputs change without a strobe; outputs must not move
    operand = ~a; statusIn = ~st;
    @(negedge clk);
    check("R2 valid clear", outValid, 0);
    check("R2 hold", {result, statusOut}, {r, s});
  endtask

  initial begin
    rst = 1'b1; earlyRev = 1'b0; inValid = 1'b0;
    opSel = 2'b00; operand = 8'hA5; statusIn = 8'hFF;
    repeat (3) @(negedge clk);
    check("R1 reset result", result, 0);
    check("R1 reset status", statusOut, 0);
    check("R1 reset valid", outValid, 0);
    rst = 1'b0;
    for (int rev = 0; rev < 2; rev++) begin
      for (int op = 0; op < 4; op++) begin
        for (int a = 0; a < 256; a++) begin
          for (int c = 0; c < 2; c++) begin
            logic [7:0] st;
            st = {a[3:0] ^ 4'h9, a[7:6] ^ 2'b10, 1'b0, c[0]};
            st[7] = a[5];
            st[1] = a[0];
            runOne(op[1:0], rev[0], a[7:0], st);
          end
        end
      end
    end
    // Spot values for the defective rotate-right
    runOne(2'b11, 1'b1, 8'h01, 8'h01);
    runOne(2'b11, 1'b1, 8'hFF, 8'h00);
    runOne(2'b11, 1'b1, 8'h80, 8'h01);
    // Reset during operation clears everything again
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset again", {result, statusOut, 7'b0, outValid}, 0);
    rst = 1'b0;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule